// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block gathers six interrupt causes from a three-channel serial transmitter. There are two causes per channel: transmit FIFO empty and end of transmission. It merges them into one shared, active-low, open-drain interrupt request toward a 16-bit asynchronous processor bus. Each cause has a sticky pending flag and an enable bit. Software clears flags by writing ones, and it programs the upper bits of the returned vector.

The block sits in a daisy chain of interrupting devices. The chain runs through an active-low enable-in and enable-out pair. When the processor acknowledges and no higher device is asking, the block completes a handshake. It drives an 8-bit vector naming its highest-priority pending cause on the low data byte and asserts the transfer acknowledge. When the acknowledge input is released, the block clears the served flag and frees the bus on the next clock. Plain chip-select register accesses share the same transfer acknowledge.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset no flag is pending, every cause is enabled (enable register reads 6'h3f), the vector base is 0, the request is released, dtack_no is high and data_oe_o is low.
- R2: A one-cycle high pulse on ev_fifo_empty_i[c] or ev_eot_i[c] sets a pending flag. The status register (address 3) shows that flag in bit 2*c+k, where k=0 for FIFO empty and k=1 for end of transmission.
- R3: irq_pull_o is high exactly when some pending flag has its enable bit set. Enables are at address 0, bits 5..0, with the same layout as R2 and 1 meaning enabled.
- R4: Among enabled pending causes, channel 0 wins over 1, and 1 wins over 2. Inside a channel, end of transmission wins over FIFO empty.
- R5: The vector is {base[4:0], channel[1:0], k}. The base is written at address 2, bits 4..0.
- R6: An acknowledge cycle starts only when iack_ni and iei_ni are both low and irq_pull_o is high. From the next clock, dtack_no is low, data_oe_o is high and data_o[7:0] holds the vector. Otherwise dtack_no stays high.
- R7: ieo_no is low exactly when iei_ni is low and irq_pull_o is low.
- R8: When iack_ni is seen high during an acknowledge cycle, the served flag clears. On the next clock dtack_no returns high and data_oe_o low.
- R9: Writing ones at address 1 clears the matching flags. An event in the same cycle as a clear leaves its flag set.
- R10: With cs_ni low and no acknowledge in progress, dtack_no goes low on the next clock. For a read (rw_i high), data_oe_o is high and data_o carries the addressed register.
- R11: The vector stays unchanged for the whole acknowledge cycle, even if a higher-priority cause arrives meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_fifo_empty_i | input | 3 | Per-channel FIFO-empty event pulse |
| ev_eot_i | input | 3 | Per-channel end-of-transmission event pulse |
| cs_ni | input | 1 | Register select, active low |
| rw_i | input | 1 | 1 read, 0 write |
| addr_i | input | 2 | Register address |
| data_i | input | 16 | Write data |
| data_o | output | 16 | Read data or vector |
| data_oe_o | output | 1 | Data bus drive enable |
| dtack_no | output | 1 | Transfer acknowledge, active low |
| iack_ni | input | 1 | Interrupt acknowledge, active low |
| iei_ni | input | 1 | Chain enable in, active low |
| ieo_no | output | 1 | Chain enable out, active low |
| irq_pull_o | output | 1 | Pull-low enable of the open-drain request |

## Verification
The assertions check on every cycle the chain gating of enable-out, the rule that an acknowledge never starts without enable-in, the acknowledge outputs and the vector holding steady during a handshake, and the one-clock release. Priority order, the vector encoding, set-beats-clear collisions, and flag clearing after service can only be shown by the bench. It compares read-backs and vectors against a reference model under random events, enables and chain states.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int N_CH   = 3;
  localparam int N_SRC  = 2 * N_CH;
  localparam int SRC_W  = $clog2(N_SRC);
  localparam int CH_W   = 2;
  localparam int BASE_W = 5;
  localparam int VEC_W  = BASE_W + CH_W + 1;

  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_CLR  = 2'd1,
    REG_BASE = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;   // set wins over clear
      else if (clr_i[g]) pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_vec_pkg::*;
(
  input  logic [N_SRC-1:0] active_i,
  output logic             valid_o,
  output logic [SRC_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    // scan lowest priority first; later hits override
    for (int ch = N_CH - 1; ch >= 0; ch--) begin
      for (int k = 0; k < 2; k++) begin
        if (active_i[2*ch+k]) begin
          valid_o = 1'b1;
          idx_o   = SRC_W'(2*ch+k);
        end
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   ev_fifo_empty_i,
  input  logic [N_CH-1:0]   ev_eot_i,
  input  logic              cs_ni,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              dtack_no,
  input  logic              iack_ni,
  input  logic              iei_ni,
  output logic              ieo_no,
  output logic              irq_pull_o
);
  logic [N_SRC-1:0]  pend, en_q, set, clr, active;
  logic [BASE_W-1:0] base_q;
  logic              req, sel_vld;
  logic [SRC_W-1:0]  sel, sel_q;
  logic              ack_q, reg_ack_q, reg_rd_q;
  logic [DATA_W-1:0] rdata_q, rdata;
  logic              ack_start, ack_end, reg_sel, wr;
  logic [VEC_W-1:0]  vec;

  for (genvar c = 0; c < N_CH; c++) begin : g_ev
    assign set[2*c]   = ev_fifo_empty_i[c];
    assign set[2*c+1] = ev_eot_i[c];
  end

  assign active = pend & en_q;
  assign req    = |active;

  irq_prio_enc u_prio (
    .active_i (active),
    .valid_o  (sel_vld),
    .idx_o    (sel)
  );

  assign ack_start = !ack_q && !iack_ni && !iei_ni && req;
  assign ack_end   = ack_q && iack_ni;
  assign reg_sel   = !cs_ni && iack_ni && !ack_q;
  assign wr        = reg_sel && !rw_i;

  always_comb begin
    clr = '0;
    if (wr && addr_i == ADDR_W'(REG_CLR)) clr = data_i[N_SRC-1:0];
    if (ack_end) clr[sel_q] = 1'b1;
  end

  irq_pend_bank #(.N(N_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (clr),
    .pend_o (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '1;
      base_q <= '0;
    end else if (wr) begin
      if (addr_i == ADDR_W'(REG_EN))   en_q   <= data_i[N_SRC-1:0];
      if (addr_i == ADDR_W'(REG_BASE)) base_q <= data_i[BASE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      sel_q <= '0;
    end else begin
      ack_q <= ack_start || (ack_q && !iack_ni);
      if (ack_start && sel_vld) sel_q <= sel;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr_i)
      ADDR_W'(REG_EN):   rdata[N_SRC-1:0]  = en_q;
      ADDR_W'(REG_BASE): rdata[BASE_W-1:0] = base_q;
      ADDR_W'(REG_STAT): rdata[N_SRC-1:0]  = pend;
      default:           rdata = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_ack_q <= 1'b0;
      reg_rd_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      reg_ack_q <= reg_sel;
      reg_rd_q  <= reg_sel && rw_i;
      if (reg_sel && rw_i) rdata_q <= rdata;
    end
  end

  assign vec        = {base_q, CH_W'(sel_q >> 1), sel_q[0]};
  assign data_o     = ack_q ? DATA_W'(vec) : rdata_q;
  assign data_oe_o  = ack_q || (reg_ack_q && reg_rd_q);
  assign dtack_no   = !(ack_q || reg_ack_q);
  assign ieo_no     = !(!iei_ni && !req);
  assign irq_pull_o = req;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irq_vec_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iack_ni,
  input logic             iei_ni,
  input logic             ieo_no,
  input logic             irq_pull_o,
  input logic             dtack_no,
  input logic             data_oe_o,
  input logic [VEC_W-1:0] vec_i,
  input logic             ack_q,
  input logic [N_SRC-1:0] pend
);
  AST_IEO_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pull_o |-> ieo_no);                                          // R7
  AST_IEO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iei_ni && !irq_pull_o) |-> !ieo_no);                           // R7
  AST_ACK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(!iei_ni && !iack_ni && irq_pull_o));      // R6
  AST_ACK_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> (!dtack_no && data_oe_o));                             // R6
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && $past(ack_q)) |-> $stable(vec_i));                     // R11
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && iack_ni) |=> (dtack_no && !data_oe_o));                // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pull_o |-> (pend != '0));                                    // R3
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .iack_ni    (iack_ni),
  .iei_ni     (iei_ni),
  .ieo_no     (ieo_no),
  .irq_pull_o (irq_pull_o),
  .dtack_no   (dtack_no),
  .data_oe_o  (data_oe_o),
  .vec_i      (data_o[7:0]),
  .ack_q      (ack_q),
  .pend       (pend)
);

// File: tb/test_irq_vec_ctrl.sv
`timescale 1ns/1ps
module test_irq_vec_ctrl;
  logic        clk = 0, rst_ni = 0;
  logic [2:0]  ev_fe = 0, ev_eot = 0;
  logic        cs_ni = 1, rw_i = 1, iack_ni = 1, iei_ni = 0;
  logic [1:0]  addr_i = 0;
  logic [15:0] data_i = 0, data_o;
  logic        data_oe_o, dtack_no, ieo_no, irq_pull_o;

  int total = 0, bad = 0;
  logic [5:0] m_pend = 0, m_en = 6'h3f;
  logic [4:0] m_base = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ev_fifo_empty_i(ev_fe), .ev_eot_i(ev_eot),
    .cs_ni(cs_ni), .rw_i(rw_i), .addr_i(addr_i), .data_i(data_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .dtack_no(dtack_no), .iack_ni(iack_ni), .iei_ni(iei_ni),
    .ieo_no(ieo_no), .irq_pull_o(irq_pull_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [8:0] exp_vec(logic [5:0] p, logic [5:0] e, logic [4:0] b);
    logic [5:0] a = p & e;
    for (int ch = 0; ch < 3; ch++)
      for (int k = 1; k >= 0; k--)
        if (a[2*ch+k]) return {1'b1, b, 2'(ch), 1'(k)};
    return 9'h0;
  endfunction

  task automatic chk_lines();
    chk(irq_pull_o == |(m_pend & m_en), "R3 irq", irq_pull_o, |(m_pend & m_en));
    chk(ieo_no == !(!iei_ni && !(|(m_pend & m_en))), "R7 ieo", ieo_no,
        !(!iei_ni && !(|(m_pend & m_en))));
  endtask

  task automatic pulse(input logic [2:0] fe, input logic [2:0] eot);
    ev_fe = fe; ev_eot = eot;
    step();
    ev_fe = 0; ev_eot = 0;
    for (int c = 0; c < 3; c++) begin
      if (fe[c])  m_pend[2*c]   = 1;
      if (eot[c]) m_pend[2*c+1] = 1;
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    cs_ni = 0; rw_i = 0; addr_i = a; data_i = d;
    step();
    cs_ni = 1; rw_i = 1;
    chk(dtack_no == 0 && data_oe_o == 0, "R10 write dtack", dtack_no, 0);
    case (a)
      2'd0: m_en = d[5:0];
      2'd1: m_pend = m_pend & ~d[5:0];
      2'd2: m_base = d[4:0];
      default: ;
    endcase
    step();
    chk(dtack_no == 1, "R10 write release", dtack_no, 1);
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [15:0] exp, input string req);
    cs_ni = 0; rw_i = 1; addr_i = a;
    step();
    cs_ni = 1;
    chk(dtack_no == 0 && data_oe_o == 1, "R10 read dtack", {dtack_no, data_oe_o}, 1);
    chk(data_o == exp, req, data_o, exp);
    step();
  endtask

  task automatic ack_cycle(input logic iei);
    logic [8:0] v;
    iei_ni = iei;
    #0.1;
    chk_lines();
    v = exp_vec(m_pend, m_en, m_base);
    iack_ni = 0;
    step();
    if (v[8] && !iei) begin
      chk(dtack_no == 0 && data_oe_o == 1, "R6 ack drive", {dtack_no, data_oe_o}, 1);
      chk(data_o[7:0] == v[7:0], "R4 R5 vector", data_o[7:0], v[7:0]);
    end else begin
      chk(dtack_no == 1, "R6 no ack", dtack_no, 1);
    end
    iack_ni = 1;
    step();
    chk(dtack_no == 1 && data_oe_o == 0, "R8 release", {dtack_no, data_oe_o}, 2);
    if (v[8] && !iei) m_pend[{v[2:1], v[0]}] = 0;
    iei_ni = 0;
    rd_reg(2'd3, {10'h0, m_pend}, "R8 served flag cleared");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog timeout");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq_pull_o == 0 && dtack_no == 1 && data_oe_o == 0, "R1 outputs",
        {irq_pull_o, dtack_no, data_oe_o}, 3'b010);
    rd_reg(2'd0, 16'h003f, "R1 enables");
    rd_reg(2'd3, 16'h0000, "R1 pending");
    rd_reg(2'd2, 16'h0000, "R1 base");

    // R2 set and status layout
    pulse(3'b010, 3'b000);
    rd_reg(2'd3, 16'h0004, "R2 ch1 fifo empty bit2");
    pulse(3'b000, 3'b100);
    rd_reg(2'd3, 16'h0024, "R2 ch2 eot bit5");
    chk_lines();

    // R3 masking
    wr_reg(2'd0, 16'h0000);
    chk(irq_pull_o == 0, "R3 masked", irq_pull_o, 0);
    wr_reg(2'd0, 16'h003f);

    // R5 base and R4 priority: ch2 eot vs ch1 fifo -> ch1
    wr_reg(2'd2, 16'h0015);
    ack_cycle(0);
    // R6 chain blocked
    ack_cycle(1);

    // R11 vector hold with late higher event
    v = exp_vec(m_pend, m_en, m_base);
    iack_ni = 0;
    step();
    pulse(3'b000, 3'b001);
    chk(data_o[7:0] == v[7:0], "R11 vector held", data_o[7:0], v[7:0]);
    iack_ni = 1;
    step();
    m_pend[{v[2:1], v[0]}] = 0;
    rd_reg(2'd3, {10'h0, m_pend}, "R11 new flag kept");

    // R9 clear versus simultaneous event
    cs_ni = 0; rw_i = 0; addr_i = 2'd1; data_i = 16'h003f; ev_fe = 3'b001;
    step();
    cs_ni = 1; ev_fe = 0;
    m_pend = 6'h01;
    step();
    rd_reg(2'd3, 16'h0001, "R9 set wins over clear");
    wr_reg(2'd1, 16'h0001);
    rd_reg(2'd3, 16'h0000, "R9 clear");

    // random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 4))
        0: pulse(3'($urandom), 3'($urandom));
        1: wr_reg(2'd0, 16'($urandom_range(0, 63)));
        2: wr_reg(2'd1, 16'($urandom_range(0, 63)));
        3: ack_cycle(1'($urandom_range(0, 3) == 0));
        default: begin
          wr_reg(2'd2, 16'($urandom_range(0, 31)));
          rd_reg(2'd3, {10'h0, m_pend}, "R2 status");
        end
      endcase
      chk_lines();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule